// File: doc/BRIEF.md
# Saturating Error Counter and Interrupt Aggregator

This block collects error events reported by a memory protection datapath and by the surrounding infrastructure: single-bit corrected errors (SEC), double-bit detected errors (DED), parity errors and serial-bus timeouts. Each event kind feeds a small saturating counter. Software can raise a counter by writing an amount to its field and lower it by writing an amount to a paired clear field. For every SEC event the block records the failing bit position. For every SEC or DED event it records the failing row, which is the byte address divided by four.

The SEC and DED classes each have an enable, a pending flag and an end-of-interrupt register. While its counter is non-zero and its enable is set, a class sends a one-cycle interrupt pulse to the host. It sends no further pulse until software writes end-of-interrupt. A flag also records the case where a new single-bit error arrives while a correction writeback is still outstanding.

Register access uses a simple port with valid, write, word address and data. Read data depends only on the address, combinationally. Events arrive as single-cycle pulses.

Top module: `err_event_aggr`

## Requirements
- R1: The SEC counter (word 0, bits 1:0) and the DED counter (word 0, bits 3:2) each count up by one on every hardware event of their kind. A write to word 0 adds each field's value to its counter, and a counter never goes above 3.
- R2: A write to word 0 subtracts bits 9:8 from the SEC counter and bits 11:10 from the DED counter. A counter never goes below 0, and these clear fields read back as 0.
- R3: When a hardware event and a software write hit the same counter in one cycle, the counter becomes the current value plus the event plus the written increment minus the written decrement. The result is then clamped to the range 0..3.
- R4: Word 0 bit 4 is set by an SEC event that arrives while the wb_pending input is high, and it stays set until a write to word 0 with bit 12 set. If the set and the clear happen in the same cycle, the set wins.
- R5: The SEC enable is set by writing 1 to bit 0 of word 5 and cleared by writing 1 to bit 0 of word 6. The DED enable uses words 9 and 10 in the same way. Writing 0 changes nothing, and both words of a pair read back the current enable in bit 0.
- R6: A class issues a one-cycle pulse on its interrupt output one cycle after the cycle in which its counter is non-zero, its enable is set and its pending flag is clear. The pulse sets the pending flag (word 4 for SEC, word 8 for DED, bit 0). Writing 1 to bit 0 of the end-of-interrupt word (word 3 for SEC, word 7 for DED) clears the pending flag, and the pulse is then issued again if the counter is still non-zero.
- R7: An SEC event stores the bit position in word 0 bits 31:16; a DED event leaves it unchanged. An SEC or DED event stores its byte address shifted right by two in word 1.
- R8: Word 2 bit 0 reads the current level of the wb_pending input.
- R9: The parity counter (bits 1:0) and the timeout counter (bits 3:2) use the same 0..3 saturating arithmetic. Writes to word 13 add to them, writes to word 14 subtract from them, and both words read back the counters. Hardware parity events count only while enable bit 0 is set, and timeout events count only while enable bit 1 is set. These enables are set through word 11 and cleared through word 12, both of which read back the enables. Software writes apply whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W (4) | Word address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data of the addressed word (combinational) |
| ev_sec | input | 1 | Single-bit corrected error pulse |
| ev_ded | input | 1 | Double-bit detected error pulse |
| ev_bitpos | input | POS_W (16) | Failing bit position, valid with ev_sec |
| ev_byte_addr | input | ROW_W+2 (32) | Failing byte address, valid with ev_sec or ev_ded |
| wb_pending | input | 1 | Correction writeback outstanding |
| ev_parity | input | 1 | Parity error pulse |
| ev_timeout | input | 1 | Serial-bus timeout pulse |
| irq_sec | output | 1 | SEC interrupt pulse |
| irq_ded | output | 1 | DED interrupt pulse |

## Verification
The bench builds the block with its default parameters, so each counter is 2 bits wide and saturates after three events. With those values both ends of the clamp can be reached in a few cycles, including the case where an event arrives together with a write. A 16-bit bit position and a 30-bit row let the bench check field placement in word 0, and check that the byte address is divided by four. A behavioural model of counters, enables and the pending handshake predicts both interrupt outputs on every clock and every register read.

// File: rtl/err_aggr_pkg.sv
package err_aggr_pkg;

  // Word addresses of the register port
  typedef enum logic [3:0] {
    RA_STAT     = 4'h0,
    RA_ROW      = 4'h1,
    RA_WB       = 4'h2,
    RA_SEC_EOI  = 4'h3,
    RA_SEC_PEND = 4'h4,
    RA_SEC_ENS  = 4'h5,
    RA_SEC_ENC  = 4'h6,
    RA_DED_EOI  = 4'h7,
    RA_DED_PEND = 4'h8,
    RA_DED_ENS  = 4'h9,
    RA_DED_ENC  = 4'hA,
    RA_AGG_ENS  = 4'hB,
    RA_AGG_ENC  = 4'hC,
    RA_AGG_SET  = 4'hD,
    RA_AGG_CLR  = 4'hE
  } reg_word_e;

  // Counter slots
  localparam int CI_SEC = 0;
  localparam int CI_DED = 1;
  localparam int CI_PAR = 2;
  localparam int CI_TMO = 3;

  // Net update of a saturating counter: add, subtract, then clamp to 0..maxv
  function automatic int sat_next(int cur, int inc, int dec, int maxv);
    int s;
    s = cur + inc - dec;
    if (s < 0) s = 0;
    else if (s > maxv) s = maxv;
    return s;
  endfunction

endpackage

// File: rtl/eagg_sat_counter.sv
module eagg_sat_counter #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_inc,
  input  logic [CW-1:0] sw_inc,
  input  logic [CW-1:0] sw_dec,
  output logic [CW-1:0] count
);
  import err_aggr_pkg::*;

  localparam int MAXV = (1 << CW) - 1;

  logic [CW-1:0] count_nxt;
  logic          any_up;
  logic          any_down;

  assign any_up   = hw_inc || (sw_inc != '0);
  assign any_down = (sw_dec != '0);

  always_comb count_nxt = CW'(sat_next(int'(count), int'(hw_inc) + int'(sw_inc), int'(sw_dec), MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  // R1: adding without subtracting never lowers the count
  a_r1_up_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (any_up && !any_down) |=> (count >= $past(count)));

  // R1: a full counter stays full unless something is subtracted
  a_r1_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((count == CW'(MAXV)) && !any_down) |=> (count == CW'(MAXV)));

  // R2: subtracting without adding never raises the count
  a_r2_down_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (any_down && !any_up) |=> (count <= $past(count)));

endmodule

// File: rtl/eagg_irq_gate.sv
module eagg_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic enable,
  input  logic eoi,
  output logic irq,
  output logic pend
);
  logic fire;

  assign fire = active && enable && !pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      pend <= 1'b0;
    end else begin
      irq <= fire;
      if (fire)     pend <= 1'b1;
      else if (eoi) pend <= 1'b0;
    end
  end

  // R6: a pulse lasts exactly one cycle
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6: a pulse is always accompanied by the pending flag
  a_r6_pend_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend);

  // R6: without end-of-interrupt the pending flag holds and no pulse follows
  a_r6_hold_until_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !eoi) |=> (pend && !irq));

  // R5: a pulse only starts when the enable was set
  a_r5_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(enable));

endmodule

// File: rtl/err_event_aggr.sv
module err_event_aggr #(
  parameter int CNT_W  = 2,
  parameter int POS_W  = 16,
  parameter int ROW_W  = 30,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_sec,
  input  logic              ev_ded,
  input  logic [POS_W-1:0]  ev_bitpos,
  input  logic [ROW_W+1:0]  ev_byte_addr,
  input  logic              wb_pending,
  input  logic              ev_parity,
  input  logic              ev_timeout,
  output logic              irq_sec,
  output logic              irq_ded
);
  import err_aggr_pkg::*;

  localparam int N_CNT    = 4;
  localparam int N_IRQ    = 2;
  localparam int CLR_LO   = 8;
  localparam int OTHER_B  = 2 * CNT_W;
  localparam int OTHER_CB = CLR_LO + 2 * CNT_W;
  localparam int POS_LO   = 16;

  // Decoded write strobes
  logic wr_any;
  logic wr_stat, wr_agg_set, wr_agg_clr;
  logic wr_sec_ens, wr_sec_enc, wr_ded_ens, wr_ded_enc, wr_agg_ens, wr_agg_enc;
  logic [N_IRQ-1:0] eoi_wr;

  assign wr_any     = reg_valid && reg_write;
  assign wr_stat    = wr_any && (reg_addr == ADDR_W'(RA_STAT));
  assign wr_agg_set = wr_any && (reg_addr == ADDR_W'(RA_AGG_SET));
  assign wr_agg_clr = wr_any && (reg_addr == ADDR_W'(RA_AGG_CLR));
  assign wr_sec_ens = wr_any && (reg_addr == ADDR_W'(RA_SEC_ENS)) && reg_wdata[0];
  assign wr_sec_enc = wr_any && (reg_addr == ADDR_W'(RA_SEC_ENC)) && reg_wdata[0];
  assign wr_ded_ens = wr_any && (reg_addr == ADDR_W'(RA_DED_ENS)) && reg_wdata[0];
  assign wr_ded_enc = wr_any && (reg_addr == ADDR_W'(RA_DED_ENC)) && reg_wdata[0];
  assign wr_agg_ens = wr_any && (reg_addr == ADDR_W'(RA_AGG_ENS));
  assign wr_agg_enc = wr_any && (reg_addr == ADDR_W'(RA_AGG_ENC));
  assign eoi_wr[CI_SEC] = wr_any && (reg_addr == ADDR_W'(RA_SEC_EOI)) && reg_wdata[0];
  assign eoi_wr[CI_DED] = wr_any && (reg_addr == ADDR_W'(RA_DED_EOI)) && reg_wdata[0];

  logic wdata_unused;
  assign wdata_unused = ^reg_wdata;

  // Enables: 0 SEC, 1 DED, 2 parity, 3 timeout
  logic [N_CNT-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      if (wr_sec_ens) en_q[CI_SEC] <= 1'b1;
      if (wr_sec_enc) en_q[CI_SEC] <= 1'b0;
      if (wr_ded_ens) en_q[CI_DED] <= 1'b1;
      if (wr_ded_enc) en_q[CI_DED] <= 1'b0;
      if (wr_agg_ens && reg_wdata[0]) en_q[CI_PAR] <= 1'b1;
      if (wr_agg_enc && reg_wdata[0]) en_q[CI_PAR] <= 1'b0;
      if (wr_agg_ens && reg_wdata[1]) en_q[CI_TMO] <= 1'b1;
      if (wr_agg_enc && reg_wdata[1]) en_q[CI_TMO] <= 1'b0;
    end
  end

  // Counter inputs
  logic [N_CNT-1:0] hw_inc;
  logic [CNT_W-1:0] sw_inc [N_CNT];
  logic [CNT_W-1:0] sw_dec [N_CNT];
  logic [CNT_W-1:0] cnt    [N_CNT];

  always_comb begin
    hw_inc[CI_SEC] = ev_sec;
    hw_inc[CI_DED] = ev_ded;
    hw_inc[CI_PAR] = ev_parity  && en_q[CI_PAR];
    hw_inc[CI_TMO] = ev_timeout && en_q[CI_TMO];
    sw_inc[CI_SEC] = wr_stat    ? reg_wdata[0 +: CNT_W]              : '0;
    sw_inc[CI_DED] = wr_stat    ? reg_wdata[CNT_W +: CNT_W]          : '0;
    sw_dec[CI_SEC] = wr_stat    ? reg_wdata[CLR_LO +: CNT_W]         : '0;
    sw_dec[CI_DED] = wr_stat    ? reg_wdata[CLR_LO + CNT_W +: CNT_W] : '0;
    sw_inc[CI_PAR] = wr_agg_set ? reg_wdata[0 +: CNT_W]              : '0;
    sw_inc[CI_TMO] = wr_agg_set ? reg_wdata[CNT_W +: CNT_W]          : '0;
    sw_dec[CI_PAR] = wr_agg_clr ? reg_wdata[0 +: CNT_W]              : '0;
    sw_dec[CI_TMO] = wr_agg_clr ? reg_wdata[CNT_W +: CNT_W]          : '0;
  end

  genvar gc;
  for (gc = 0; gc < N_CNT; gc++) begin : g_cnt
    eagg_sat_counter #(.CW(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_inc (hw_inc[gc]),
      .sw_inc (sw_inc[gc]),
      .sw_dec (sw_dec[gc]),
      .count  (cnt[gc])
    );
  end

  // Interrupt gating per class
  logic [N_IRQ-1:0] irq_v;
  logic [N_IRQ-1:0] pend_v;

  genvar gi;
  for (gi = 0; gi < N_IRQ; gi++) begin : g_irq
    eagg_irq_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (cnt[gi] != '0),
      .enable (en_q[gi]),
      .eoi    (eoi_wr[gi]),
      .irq    (irq_v[gi]),
      .pend   (pend_v[gi])
    );
  end

  assign irq_sec = irq_v[CI_SEC];
  assign irq_ded = irq_v[CI_DED];

  // Capture and sticky flag
  logic             sec_over_wb;
  logic             other_clr;
  logic             other_q;
  logic [POS_W-1:0] pos_q;
  logic [ROW_W-1:0] row_q;

  assign sec_over_wb = ev_sec && wb_pending;
  assign other_clr   = wr_stat && reg_wdata[OTHER_CB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      other_q <= 1'b0;
      pos_q   <= '0;
      row_q   <= '0;
    end else begin
      if (sec_over_wb)    other_q <= 1'b1;
      else if (other_clr) other_q <= 1'b0;
      if (ev_sec)           pos_q <= ev_bitpos;
      if (ev_sec || ev_ded) row_q <= ev_byte_addr[ROW_W+1:2];
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(RA_STAT): begin
        reg_rdata[0 +: CNT_W]      = cnt[CI_SEC];
        reg_rdata[CNT_W +: CNT_W]  = cnt[CI_DED];
        reg_rdata[OTHER_B]         = other_q;
        reg_rdata[POS_LO +: POS_W] = pos_q;
      end
      ADDR_W'(RA_ROW):      reg_rdata[ROW_W-1:0] = row_q;
      ADDR_W'(RA_WB):       reg_rdata[0] = wb_pending;
      ADDR_W'(RA_SEC_PEND): reg_rdata[0] = pend_v[CI_SEC];
      ADDR_W'(RA_SEC_ENS),
      ADDR_W'(RA_SEC_ENC):  reg_rdata[0] = en_q[CI_SEC];
      ADDR_W'(RA_DED_PEND): reg_rdata[0] = pend_v[CI_DED];
      ADDR_W'(RA_DED_ENS),
      ADDR_W'(RA_DED_ENC):  reg_rdata[0] = en_q[CI_DED];
      ADDR_W'(RA_AGG_ENS),
      ADDR_W'(RA_AGG_ENC):  reg_rdata[1:0] = {en_q[CI_TMO], en_q[CI_PAR]};
      ADDR_W'(RA_AGG_SET),
      ADDR_W'(RA_AGG_CLR): begin
        reg_rdata[0 +: CNT_W]     = cnt[CI_PAR];
        reg_rdata[CNT_W +: CNT_W] = cnt[CI_TMO];
      end
      default: reg_rdata = '0;
    endcase
  end

  // R4: the flag stays set until its clear is written
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (other_q && !other_clr) |=> other_q);

  // R7: the bit position only moves on an SEC event
  a_r7_pos_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sec |=> $stable(pos_q));

  // R7: the row only moves on an SEC or DED event
  a_r7_row_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_sec || ev_ded) |=> $stable(row_q));

  // R9: a disabled parity source with no software add cannot raise its count
  a_r9_par_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[CI_PAR] && !wr_agg_set) |=> (cnt[CI_PAR] <= $past(cnt[CI_PAR])));

endmodule

// File: tb/err_event_aggr_bench.sv
`timescale 1ns/1ps
module err_event_aggr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_valid = 1'b0, b_write = 1'b0;
  logic [3:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic        e_sec = 1'b0, e_ded = 1'b0, e_wb = 1'b0, e_par = 1'b0, e_to = 1'b0;
  logic [15:0] e_pos = '0;
  logic [31:0] e_addr = '0;
  logic        irq_sec, irq_ded;

  int checks = 0, errors = 0;
  bit started = 0, done = 0;

  always #2 clk = ~clk;

  err_event_aggr u_err_event_aggr (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(b_valid), .reg_write(b_write), .reg_addr(b_addr),
    .reg_wdata(b_wdata), .reg_rdata(rdata),
    .ev_sec(e_sec), .ev_ded(e_ded), .ev_bitpos(e_pos), .ev_byte_addr(e_addr),
    .wb_pending(e_wb), .ev_parity(e_par), .ev_timeout(e_to),
    .irq_sec(irq_sec), .irq_ded(irq_ded)
  );

  // Behavioural reference model
  int m_cnt[4];
  bit m_en[4];
  bit m_pend[2], m_irq[2];
  bit m_other;
  int m_pos, m_row;

  function automatic int clamp3(int v);
    return (v < 0) ? 0 : ((v > 3) ? 3 : v);
  endfunction

  task automatic model_step();
    bit w;
    bit f[2];
    bit eoi[2];
    int inc[4], dec[4], hw[4];
    w = b_valid && b_write;
    for (int k = 0; k < 2; k++) f[k] = (m_cnt[k] != 0) && m_en[k] && !m_pend[k];
    for (int k = 0; k < 4; k++) begin inc[k] = 0; dec[k] = 0; end
    if (w && b_addr == 0) begin
      inc[0] = b_wdata[1:0];  inc[1] = b_wdata[3:2];
      dec[0] = b_wdata[9:8];  dec[1] = b_wdata[11:10];
    end
    if (w && b_addr == 13) begin inc[2] = b_wdata[1:0]; inc[3] = b_wdata[3:2]; end
    if (w && b_addr == 14) begin dec[2] = b_wdata[1:0]; dec[3] = b_wdata[3:2]; end
    hw[0] = e_sec; hw[1] = e_ded; hw[2] = e_par && m_en[2]; hw[3] = e_to && m_en[3];
    for (int k = 0; k < 4; k++) m_cnt[k] = clamp3(m_cnt[k] + hw[k] + inc[k] - dec[k]);
    if (e_sec && e_wb) m_other = 1;
    else if (w && b_addr == 0 && b_wdata[12]) m_other = 0;
    if (e_sec) m_pos = e_pos;
    if (e_sec || e_ded) m_row = int'(e_addr >> 2);
    eoi[0] = w && b_addr == 3 && b_wdata[0];
    eoi[1] = w && b_addr == 7 && b_wdata[0];
    for (int k = 0; k < 2; k++) begin
      m_irq[k] = f[k];
      if (f[k]) m_pend[k] = 1;
      else if (eoi[k]) m_pend[k] = 0;
    end
    if (w && b_addr == 5  && b_wdata[0]) m_en[0] = 1;
    if (w && b_addr == 6  && b_wdata[0]) m_en[0] = 0;
    if (w && b_addr == 9  && b_wdata[0]) m_en[1] = 1;
    if (w && b_addr == 10 && b_wdata[0]) m_en[1] = 0;
    if (w && b_addr == 11) begin if (b_wdata[0]) m_en[2] = 1; if (b_wdata[1]) m_en[3] = 1; end
    if (w && b_addr == 12) begin if (b_wdata[0]) m_en[2] = 0; if (b_wdata[1]) m_en[3] = 0; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin m_cnt[k] = 0; m_en[k] = 0; end
      m_pend[0] = 0; m_pend[1] = 0; m_irq[0] = 0; m_irq[1] = 0;
      m_other = 0; m_pos = 0; m_row = 0;
    end else begin
      model_step();
    end
  end

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a)
      4'd0:        return 32'((m_pos << 16) | (int'(m_other) << 4) | (m_cnt[1] << 2) | m_cnt[0]);
      4'd1:        return 32'(m_row);
      4'd2:        return {31'd0, e_wb};
      4'd4:        return {31'd0, m_pend[0]};
      4'd5, 4'd6:  return {31'd0, m_en[0]};
      4'd8:        return {31'd0, m_pend[1]};
      4'd9, 4'd10: return {31'd0, m_en[1]};
      4'd11, 4'd12: return {30'd0, m_en[3], m_en[2]};
      4'd13, 4'd14: return 32'((m_cnt[3] << 2) | m_cnt[2]);
      default:     return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // R6: interrupt outputs compared with the model on every clock
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      chk("R6 irq_sec", {31'd0, irq_sec}, {31'd0, m_irq[0]});
      chk("R6 irq_ded", {31'd0, irq_ded}, {31'd0, m_irq[1]});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    b_valid = 1; b_write = 1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_valid = 0; b_write = 0; b_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, string tag);
    b_valid = 1; b_write = 0; b_addr = a;
    #1;
    chk(tag, rdata, exp_read(a));
    @(negedge clk);
    b_valid = 0;
  endtask

  task automatic sec_ev(logic [15:0] pos, logic [31:0] ba);
    e_sec = 1; e_pos = pos; e_addr = ba;
    @(negedge clk);
    e_sec = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; started = 1;
    // Reset state
    rd(4'd0, "R1 reset stat");
    rd(4'd5, "R5 reset sec enable");
    rd(4'd13, "R9 reset agg counters");
    rd(4'd4, "R6 reset sec pending");
    // R5: enables, zero write no effect
    wr(4'd5, 32'd1);
    rd(4'd6, "R5 sec enable via clear word");
    wr(4'd6, 32'd0);
    rd(4'd5, "R5 zero clear write ignored");
    // R1/R7: SEC events, capture and saturation
    sec_ev(16'd5, 32'h0000_0040);
    idle(2);
    rd(4'd0, "R1 R7 one sec");
    rd(4'd1, "R7 row is addr/4");
    rd(4'd4, "R6 sec pending after pulse");
    sec_ev(16'd7, 32'h0000_0100);
    sec_ev(16'd9, 32'h0000_0104);
    sec_ev(16'd11, 32'h0000_0108);
    rd(4'd0, "R1 sec saturates at 3");
    // R2: subtract
    wr(4'd0, 32'h0000_0200);
    rd(4'd0, "R2 sec minus 2");
    wr(4'd0, 32'h0000_0003);
    rd(4'd0, "R1 write add clamps");
    // R6: eoi with nonzero count reissues
    wr(4'd3, 32'd1);
    idle(2);
    rd(4'd4, "R6 reissued after eoi");
    wr(4'd0, 32'h0000_0300);
    rd(4'd0, "R2 clamps at 0");
    wr(4'd3, 32'd1);
    idle(2);
    rd(4'd4, "R6 no reissue at zero");
    // R7: DED leaves bit position, updates row; irq gated by enable
    e_ded = 1; e_pos = 16'hBEEF; e_addr = 32'h0000_0800;
    @(negedge clk); e_ded = 0;
    idle(2);
    rd(4'd0, "R7 ded keeps bitpos");
    rd(4'd1, "R7 ded row");
    rd(4'd8, "R5 ded disabled no pending");
    wr(4'd9, 32'd1);
    idle(2);
    rd(4'd8, "R6 ded pending after enable");
    // R3: simultaneous event and write
    b_valid = 1; b_write = 1; b_addr = 4'd0; b_wdata = 32'h0000_0001; e_sec = 1; e_pos = 16'd3;
    @(negedge clk);
    b_valid = 0; b_write = 0; e_sec = 0;
    rd(4'd0, "R3 event plus write");
    b_valid = 1; b_write = 1; b_addr = 4'd0; b_wdata = 32'h0000_0102; e_sec = 1; e_pos = 16'd4;
    @(negedge clk);
    b_valid = 0; b_write = 0; e_sec = 0;
    rd(4'd0, "R3 net then clamp");
    // R4 / R8: sec during writeback
    e_wb = 1;
    rd(4'd2, "R8 writeback level");
    sec_ev(16'd2, 32'h0000_0010);
    e_wb = 0;
    rd(4'd0, "R4 flag set");
    rd(4'd2, "R8 writeback low");
    e_wb = 1; e_sec = 1;
    b_valid = 1; b_write = 1; b_addr = 4'd0; b_wdata = 32'h0000_1000;
    @(negedge clk);
    b_valid = 0; b_write = 0; e_sec = 0; e_wb = 0;
    rd(4'd0, "R4 set wins over clear");
    wr(4'd0, 32'h0000_1000);
    rd(4'd0, "R4 flag cleared");
    // R9: parity / timeout
    e_par = 1; e_to = 1; @(negedge clk); e_par = 0; e_to = 0;
    rd(4'd13, "R9 disabled sources ignored");
    wr(4'd11, 32'd1);
    rd(4'd12, "R9 parity enable readback");
    e_par = 1; e_to = 1; @(negedge clk); e_par = 0; e_to = 0;
    rd(4'd13, "R9 parity counts timeout not");
    wr(4'd11, 32'd2);
    e_to = 1; @(negedge clk); e_to = 0;
    wr(4'd13, 32'h0000_000F);
    rd(4'd14, "R9 set saturates");
    wr(4'd14, 32'h0000_0009);
    rd(4'd13, "R9 clear subtracts");
    wr(4'd12, 32'd3);
    e_par = 1; @(negedge clk); e_par = 0;
    rd(4'd13, "R9 disabled again");
    rd(4'd15, "R9 unmapped reads zero");
    idle(4);
    finish_run();
  end

endmodule